// File: doc/BRIEF.md
# Universal Synchronous Serial Shifter

This block is the bit engine of a small controller's serial port. One 8-bit shift register serves both directions: each shift step moves the register left, takes the new least significant bit from the data-input pin, and puts the old top bit out on the wire. A 4-bit step counter runs with the shift register from the same clock source. When the counter wraps, an overflow flag is set. Host software does all framing, addressing and acknowledge handling. It reads and writes the block through a small parallel register bus.

The block has two wire modes. In three-wire mode the top bit appears on a push-pull data-out pin. In two-wire mode the same bit pulls an open-drain data line low, and the block pulls the clock line low while a flag needs attention. A start condition on the two-wire bus sets its own flag. The output bit passes through a hold stage. With the external clock this stage is open only while the clock pin is low, so the outgoing bit changes on the edge opposite to the one that samples input.

Shift steps can come from three clock sources: a timer tick, a software strobe, or the external clock pin. The clock and data pins pass through a two-flop synchronizer. The external clock must therefore stay at or below a quarter of the system clock in three-wire mode, and at or below a sixteenth of it in two-wire mode.

Top module: `usync_top`

Register map (bus_addr):
- 0, data: the shift register. Reads return it and writes load it.
- 1, status: bit 7 is the start flag and bit 6 the overflow flag. Writing 1 to either flag clears it. Bits 3:0 are the counter; writes load it.
- 2, control: bit 0 selects two-wire mode. Bits 2:1 select the clock source: 00 off, 01 timer tick, 10 clock pin, 11 software strobe. Bit 3 is the strobe; it is write-only and reads 0. Bit 4 enables the overflow interrupt and bit 5 the start interrupt.

## Requirements
- R1: After reset, the data, status and control registers read 0, and dout_o, dat_pull_low_o, clk_pull_low_o and irq_o are 0.
- R2: A bus write to address 0 loads the shift register, and a write to address 1 loads the counter from bits 3:0. Both read back unchanged.
- R3: A control write that has bit 3 set and source field 11 makes one step. The register shifts left, takes the synchronized data-input pin as its new bit 0, and the counter goes up by one.
- R4: dout_o shows the register's top bit one cycle after the register changes. With the pin clock source, dout_o keeps its value while the synchronized clock pin is high.
- R5: With the pin clock source, the counter goes up on every synchronized edge of the clock pin, and the register shifts on rising edges only. Sixteen edges move eight bits in and bring the counter from 0 back to 0.
- R6: The overflow flag (status bit 6) is set when a step wraps the counter from 15 to 0. Only a write of 1 to bit 6 clears it.
- R7: With source field 01, each single-cycle pulse on timer_tick makes exactly one step.
- R8: With source field 00, timer ticks, strobes and clock-pin edges leave the register and the counter unchanged.
- R9: In two-wire mode, dat_pull_low_o is the inverse of the held top bit and dout_o is 0. In three-wire mode, neither open-drain output is ever asserted.
- R10: In two-wire mode, a falling edge of the data pin while the clock pin is high sets the start flag (status bit 7). In three-wire mode the same stimulus leaves the flag clear. Writing 1 to bit 7 clears the flag.
- R11: In two-wire mode, clk_pull_low_o stays asserted while the start flag or the overflow flag is set, and is released when both are cleared.
- R12: irq_o is high when the overflow flag is set and control bit 4 is set, or when the start flag is set and control bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| timer_tick | input | 1 | One-cycle timer event used as a clock source |
| clk_pin_i | input | 1 | Serial clock pin level (three-wire clock or two-wire clock line) |
| dat_pin_i | input | 1 | Serial data-input pin level (three-wire input or two-wire data line) |
| dout_o | output | 1 | Three-wire data output |
| dat_pull_low_o | output | 1 | Open-drain pull-down for the two-wire data line |
| clk_pull_low_o | output | 1 | Open-drain pull-down for the two-wire clock line (stretch) |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong shift or counter state shows up on the bus at the next read after the faulty step, and on dout_o one cycle later. A counter that is off by one moves the overflow flag, clk_pull_low_o and irq_o by a whole step. With the pin clock, a hold stage that opens at the wrong time makes dout_o change during the clock-high phase, and the bench samples inside that phase for every bit. A start detector or flag-clear fault shows as a clock line that is never pulled low, or one that stays pulled low after the clear write.

// File: rtl/usync_pkg.sv
package usync_pkg;
  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_TIMER = 2'b01,
    SRC_PIN   = 2'b10,
    SRC_SOFT  = 2'b11
  } clk_src_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
endpackage

// File: rtl/usync_pin_sync.sv
module usync_pin_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] prev_o
);
  logic [STAGES:0][W-1:0] stg_q;
  logic [STAGES:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-1:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign level_o = stg_q[STAGES-1];
  assign prev_o  = stg_q[STAGES];
endmodule

// File: rtl/usync_shift.sv
module usync_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         din,
  input  logic         open,
  output logic [W-1:0] data_o,
  output logic         hold_o
);
  logic [W-1:0] sr_q, sr_d;
  logic         hold_q, hold_d;

  always_comb begin
    sr_d = sr_q;
    if (load)      sr_d = load_val;
    else if (step) sr_d = {sr_q[W-2:0], din};
    hold_d = open ? sr_q[W-1] : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      hold_q <= hold_d;
    end
  end

  assign data_o = sr_q;
  assign hold_o = hold_q;

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (data_o == {$past(data_o[W-2:0]), $past(din)})); // R3
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(hold_o)); // R4
endmodule

// File: rtl/usync_count.sv
module usync_count #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = step && !load && (cnt_q == TOP);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_o == W'($past(cnt_o) + 1'b1))); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_o == '0)); // R6
endmodule

// File: rtl/usync_top.sv
module usync_top
  import usync_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              timer_tick,
  input  logic              clk_pin_i,
  input  logic              dat_pin_i,
  output logic              dout_o,
  output logic              dat_pull_low_o,
  output logic              clk_pull_low_o,
  output logic              irq_o
);
  localparam int unsigned START_BIT = DATA_W - 1;
  localparam int unsigned OVF_BIT   = DATA_W - 2;

  logic [1:0] pin_lvl, pin_prev;
  logic       clk_lvl, clk_rise, clk_fall, dat_lvl, dat_fall;

  usync_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i({dat_pin_i, clk_pin_i}),
    .level_o(pin_lvl), .prev_o(pin_prev)
  );

  assign clk_lvl  = pin_lvl[0];
  assign clk_rise = pin_lvl[0] & ~pin_prev[0];
  assign clk_fall = ~pin_lvl[0] & pin_prev[0];
  assign dat_lvl  = pin_lvl[1];
  assign dat_fall = ~pin_lvl[1] & pin_prev[1];

  logic       two_wire_q, two_wire_d;
  clk_src_e   src_q, src_d;
  logic       ovf_ie_q, ovf_ie_d, start_ie_q, start_ie_d;
  logic       ovf_q, ovf_d, start_q, start_d;
  logic       wr_data, wr_stat, wr_ctrl, soft_ev;
  logic       ev_shift, ev_count, latch_open, start_set;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic       hold, cnt_wrap;

  assign wr_data = bus_wr && (bus_addr == A_DATA);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign soft_ev = wr_ctrl && bus_wdata[3] && (clk_src_e'(bus_wdata[2:1]) == SRC_SOFT);

  always_comb begin
    ev_shift = soft_ev;
    ev_count = soft_ev;
    case (src_q)
      SRC_TIMER: begin
        ev_shift = ev_shift | timer_tick;
        ev_count = ev_count | timer_tick;
      end
      SRC_PIN: begin
        ev_shift = ev_shift | clk_rise;
        ev_count = ev_count | clk_rise | clk_fall;
      end
      default: ;
    endcase
  end

  assign latch_open = (src_q != SRC_PIN) || !clk_lvl;
  assign start_set  = two_wire_q && clk_lvl && dat_fall;

  usync_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .load_val(bus_wdata),
    .step(ev_shift), .din(dat_lvl), .open(latch_open),
    .data_o(sr), .hold_o(hold)
  );

  usync_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(wr_stat), .load_val(bus_wdata[CNT_W-1:0]),
    .step(ev_count), .cnt_o(cnt), .wrap_o(cnt_wrap)
  );

  always_comb begin
    two_wire_d = two_wire_q;
    src_d      = src_q;
    ovf_ie_d   = ovf_ie_q;
    start_ie_d = start_ie_q;
    if (wr_ctrl) begin
      two_wire_d = bus_wdata[0];
      src_d      = clk_src_e'(bus_wdata[2:1]);
      ovf_ie_d   = bus_wdata[4];
      start_ie_d = bus_wdata[5];
    end
    ovf_d = ovf_q;
    if (cnt_wrap)                          ovf_d = 1'b1;
    else if (wr_stat && bus_wdata[OVF_BIT]) ovf_d = 1'b0;
    start_d = start_q;
    if (start_set)                            start_d = 1'b1;
    else if (wr_stat && bus_wdata[START_BIT]) start_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      two_wire_q <= 1'b0;
      src_q      <= SRC_OFF;
      ovf_ie_q   <= 1'b0;
      start_ie_q <= 1'b0;
      ovf_q      <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      two_wire_q <= two_wire_d;
      src_q      <= src_d;
      ovf_ie_q   <= ovf_ie_d;
      start_ie_q <= start_ie_d;
      ovf_q      <= ovf_d;
      start_q    <= start_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA: bus_rdata = sr;
      A_STAT: begin
        bus_rdata[START_BIT] = start_q;
        bus_rdata[OVF_BIT]   = ovf_q;
        bus_rdata[CNT_W-1:0] = cnt;
      end
      A_CTRL: bus_rdata = DATA_W'({start_ie_q, ovf_ie_q, 1'b0, src_q, two_wire_q});
      default: bus_rdata = '0;
    endcase
  end

  assign dout_o         = !two_wire_q && hold;
  assign dat_pull_low_o = two_wire_q && !hold;
  assign clk_pull_low_o = two_wire_q && (start_q || ovf_q);
  assign irq_o          = (ovf_q && ovf_ie_q) || (start_q && start_ie_q);

  AST_OVF_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(cnt) == '1)); // R6
  AST_START_TWO_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(two_wire_q)); // R10
  AST_STRETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_pull_low_o) && two_wire_q && !$past(wr_stat)) |-> clk_pull_low_o); // R11
  AST_DRAIN_QUIET_3W: assert property (@(posedge clk) disable iff (!rst_n)
    (!two_wire_q && !$past(two_wire_q)) |-> (!dat_pull_low_o && !clk_pull_low_o)); // R9
endmodule

// File: tb/tb_usync_top.sv
module tb_usync_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       timer_tick = 1'b0;
  logic       clk_pin_i = 1'b0;
  logic       dat_pin_i = 1'b0;
  logic       dout_o, dat_pull_low_o, clk_pull_low_o, irq_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  usync_top dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_tick(timer_tick),
    .clk_pin_i(clk_pin_i), .dat_pin_i(dat_pin_i), .dout_o(dout_o),
    .dat_pull_low_o(dat_pull_low_o), .clk_pull_low_o(clk_pull_low_o), .irq_o(irq_o)
  );

  // vector: {data preload, din bit, counter preload}
  typedef struct packed { logic [7:0] d; logic din; logic [3:0] c0; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'hA5, 1'b1, 4'd0}, '{8'h80, 1'b0, 4'd7}, '{8'hFF, 1'b0, 4'd15},
    '{8'h00, 1'b1, 4'd3}, '{8'h3C, 1'b1, 4'd14}, '{8'h81, 1'b0, 4'd9}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] tx, rx, exp_sr;
    logic [3:0] exp_c;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    rd(2'd0, v); chk("R1 data", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 pins", {4'b0, dout_o, dat_pull_low_o, clk_pull_low_o, irq_o}, 8'h00);

    // R2 register load and readback
    wr(2'd0, 8'h5A); rd(2'd0, v); chk("R2 data", v, 8'h5A);
    wr(2'd1, 8'h0B); rd(2'd1, v); chk("R2 count", v, 8'h0B);

    // R3/R4/R6 software strobe table
    wr(2'd2, 8'h06);
    foreach (VECS[i]) begin
      dat_pin_i = VECS[i].din;
      wait_n(3);
      wr(2'd1, {2'b11, 2'b00, VECS[i].c0});
      wr(2'd0, VECS[i].d);
      wr(2'd2, 8'h0E);
      exp_sr = {VECS[i].d[6:0], VECS[i].din};
      exp_c  = VECS[i].c0 + 4'd1;
      rd(2'd0, v); chk("R3 shift", v, exp_sr);
      rd(2'd1, v); chk("R3 R6 status", v, {1'b0, (VECS[i].c0 == 4'd15), 2'b00, exp_c});
      wait_n(1);
      chk("R4 dout msb", {7'b0, dout_o}, {7'b0, exp_sr[7]});
    end
    wr(2'd1, 8'h40); rd(2'd1, v); chk("R6 ovf clear", v, 8'h00);

    // R5/R4 external clock, full byte in three-wire mode
    tx = 8'h96; rx = 8'h3B;
    clk_pin_i = 1'b0;
    wr(2'd1, 8'hC0);
    wr(2'd0, tx);
    wr(2'd2, 8'h04);
    wait_n(4);
    for (int i = 0; i < 8; i++) begin
      dat_pin_i = rx[7-i];
      wait_n(4);
      clk_pin_i = 1'b1;
      wait_n(5);
      chk("R4 dout held while clock high", {7'b0, dout_o}, {7'b0, tx[7-i]});
      if (i == 7) begin
        rd(2'd1, v); chk("R5 count at 15 edges", v, 8'h0F);
      end
      clk_pin_i = 1'b0;
      wait_n(5);
    end
    rd(2'd0, v); chk("R5 received byte", v, rx);
    rd(2'd1, v); chk("R5 R6 wrap after 16 edges", v, 8'h40);
    chk("R9 three-wire no pull", {6'b0, dat_pull_low_o, clk_pull_low_o}, 8'h00);

    // R12 overflow interrupt
    wr(2'd2, 8'h14);
    chk("R12 irq on ovf", {7'b0, irq_o}, 8'h01);
    wr(2'd1, 8'h40);
    chk("R12 irq clear", {7'b0, irq_o}, 8'h00);

    // R7 timer source
    dat_pin_i = 1'b1;
    wait_n(3);
    wr(2'd2, 8'h02);
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h41);
    @(negedge clk); timer_tick = 1'b1;
    @(negedge clk); timer_tick = 1'b0;
    rd(2'd1, v); chk("R7 timer count", v, 8'h06);
    rd(2'd0, v); chk("R7 timer shift", v, 8'h83);

    // R8 source off ignores everything
    wr(2'd2, 8'h00);
    @(negedge clk); timer_tick = 1'b1;
    @(negedge clk); timer_tick = 1'b0;
    clk_pin_i = 1'b1; wait_n(5); clk_pin_i = 1'b0; wait_n(5);
    wr(2'd2, 8'h08);
    rd(2'd1, v); chk("R8 count unchanged", v, 8'h06);
    rd(2'd0, v); chk("R8 data unchanged", v, 8'h83);

    // R9 two-wire open-drain data
    wr(2'd2, 8'h07);
    wr(2'd0, 8'h00); wait_n(1);
    chk("R9 pull low on zero", {6'b0, dat_pull_low_o, dout_o}, 8'h02);
    wr(2'd0, 8'h80); wait_n(1);
    chk("R9 release on one", {6'b0, dat_pull_low_o, dout_o}, 8'h00);
    chk("R11 no stretch idle", {7'b0, clk_pull_low_o}, 8'h00);

    // R10/R11/R12 start detection and stretching
    clk_pin_i = 1'b1; dat_pin_i = 1'b1;
    wr(2'd2, 8'h25);
    wait_n(5);
    dat_pin_i = 1'b0;
    wait_n(5);
    rd(2'd1, v); chk("R10 start flag", {7'b0, v[7]}, 8'h01);
    chk("R11 stretch on start", {7'b0, clk_pull_low_o}, 8'h01);
    chk("R12 irq on start", {7'b0, irq_o}, 8'h01);
    wait_n(10);
    chk("R11 stretch held", {7'b0, clk_pull_low_o}, 8'h01);
    wr(2'd1, 8'hC0);
    rd(2'd1, v); chk("R10 start cleared", {7'b0, v[7]}, 8'h00);
    chk("R11 stretch released", {7'b0, clk_pull_low_o}, 8'h00);
    chk("R12 irq released", {7'b0, irq_o}, 8'h00);

    // R10 three-wire ignores start pattern
    dat_pin_i = 1'b1;
    wr(2'd2, 8'h24);
    wait_n(5);
    dat_pin_i = 1'b0;
    wait_n(5);
    rd(2'd1, v); chk("R10 no start in three-wire", {7'b0, v[7]}, 8'h00);
    chk("R9 three-wire no clock pull", {7'b0, clk_pull_low_o}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule